// File: doc/BRIEF.md
# Flash Page Read Buffer Set

This block sits between a simple bus-style read port and a slow flash array. It keeps a small, fully associative set of line buffers. Each line buffer holds one 128-bit flash page, the page tag, a valid bit and a flag recording that the array read which filled it needed a single-bit ECC correction. A read whose page is held in a valid line is answered in the cycle it is presented. A read that misses stalls the requester, fetches the page through a request/acknowledge array interface, returns the requested 32-bit word in the acknowledge cycle and stores the page in the least recently used (or first empty) line.

Line contents are discarded in three ways. A program/erase start raises a pending flush. A pending flush is applied only when the next non-sequential bus access is accepted, so sequential beats that are already hitting a line keep hitting. Any non-sequential access with a non-zero value in address bits [28:24] flushes the set at once. Clearing the enable input disables the set and empties it. A line filled from a corrected array read replays the single-bit ECC indication on every later hit, until the line is discarded.

Top module: `flash_page_buf`

## Requirements
- R1: A read whose page (address bits [31:4]) matches a valid line returns `bus_ready` high in the same cycle, with the 32-bit word selected by address bits [3:2] (0 selects bits [31:0] of the page, 3 selects bits [127:96]).
- R2: A read that misses keeps `bus_ready` low and holds `arr_req` high with a stable `arr_addr` equal to address bits [31:4] until `arr_ack`. In the `arr_ack` cycle, `bus_ready` is high and the requested word is returned from `arr_rdata`.
- R3: There are four lines. A fill goes to the lowest-numbered empty line, or, when no line is empty, to the line that has gone longest without a hit or fill. At most one line matches any address.
- R4: A pulse on `pe_start` makes a flush pending. Sequential accesses (`bus_nonseq` low) keep hitting. The next accepted non-sequential access empties all lines and is itself fetched from the array.
- R5: A non-sequential access with address bits [28:24] not all zero empties all lines and is served from the array. A new access of this kind flushes the set again.
- R6: While `buf_en` is low, no access hits, no fill is stored and all lines are emptied. After `buf_en` is set again, the first access to any page misses.
- R7: When a fill carries `arr_ecc_corr`, `bus_ecc1` is high on that response and on every later hit to that line. Hits on other lines leave `bus_ecc1` low.
- R8: A fetch acknowledged with `arr_err` responds with `bus_ready` and `bus_err` high and `bus_rdata` zero. The chosen line is left empty, so the next access to that page misses.
- R9: After reset, `bus_ready` and `arr_req` are low and all lines are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| buf_en | input | 1 | Line buffer enable; low disables and empties the set |
| pe_start | input | 1 | Program/erase start pulse, raises a pending flush |
| bus_valid | input | 1 | Read request present; held until `bus_ready` |
| bus_nonseq | input | 1 | High for a non-sequential access, low for a sequential beat |
| bus_addr | input | 32 | Byte address of the read |
| bus_ready | output | 1 | Response valid this cycle |
| bus_rdata | output | 32 | Read word |
| bus_err | output | 1 | Uncorrectable error response |
| bus_ecc1 | output | 1 | Single-bit corrected ECC indication on the response |
| arr_req | output | 1 | Page fetch request to the array |
| arr_addr | output | 28 | Page address of the fetch |
| arr_ack | input | 1 | Fetch complete; data and status valid |
| arr_rdata | input | 128 | Fetched page |
| arr_ecc_corr | input | 1 | Fetched page needed a single-bit correction |
| arr_err | input | 1 | Fetch ended with an uncorrectable error |

## Verification
The bench tracks the resident page set in its own expectations and checks, for each response, whether it came back with zero wait states. With this check, a wrong replacement victim, a flush applied on a sequential beat, or a flush never applied all show up as a hit where a miss was expected, or the other way round. It replays corrected-ECC status across several hits, so a design that keeps the flag only for the fill response drops `bus_ecc1`. It repeats an access after an uncorrectable fetch and after disabling the set. A design that marks the errored line valid, or fills while disabled, would then answer from the line instead of stalling.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic {
    FPB_IDLE  = 1'b0,
    FPB_FETCH = 1'b1
  } fpb_state_e;
endpackage

// File: rtl/fpb_rst_sync.sv
module fpb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/fpb_lru.sv
module fpb_lru #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] vld,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [IDX_W-1:0]   victim
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0] age_q [NUM_ENT];
  logic [IDX_W-1:0] age_d [NUM_ENT];
  logic [IDX_W-1:0] touched_age;
  logic             found_empty;

  always_comb begin
    touched_age = age_q[touch_idx];
    for (int i = 0; i < NUM_ENT; i++) begin
      age_d[i] = age_q[i];
      if (touch) begin
        if (IDX_W'(i) == touch_idx) begin
          age_d[i] = '0;
        end else if (age_q[i] < touched_age) begin
          age_d[i] = age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        age_q[i] <= IDX_W'(i);
      end
    end else if (touch) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        age_q[i] <= age_d[i];
      end
    end
  end

  always_comb begin
    victim      = '0;
    found_empty = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        victim      = IDX_W'(i);
        found_empty = 1'b1;
      end
    end
    if (!found_empty) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (age_q[i] == OLDEST) begin
          victim = IDX_W'(i);
        end
      end
    end
  end

  logic [NUM_ENT-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      age_seen[age_q[i]] = 1'b1;
    end
  end

  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    &age_seen); // R3
endmodule

// File: rtl/fpb_store.sv
module fpb_store #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = $clog2(NUM_ENT),
  parameter int TAG_W   = 28,
  parameter int LINE_W  = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               look_en,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic               flush,
  input  logic               wr_en,
  input  logic               wr_ok,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic               wr_ecc,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [LINE_W-1:0]  hit_line,
  output logic               hit_ecc,
  output logic [NUM_ENT-1:0] vld
);
  logic [NUM_ENT-1:0] vld_q;
  logic [NUM_ENT-1:0] vld_d;
  logic [NUM_ENT-1:0] ecc_q;
  logic [NUM_ENT-1:0] match;
  logic [TAG_W-1:0]   tag_q  [NUM_ENT];
  logic [LINE_W-1:0]  line_q [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic sel_wr;
    assign sel_wr = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      if (flush) begin
        vld_d[g] = 1'b0;
      end else if (sel_wr) begin
        vld_d[g] = wr_ok;
      end else begin
        vld_d[g] = vld_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else begin
        vld_q[g] <= vld_d[g];
      end
    end

    always_ff @(posedge clk) begin
      if (sel_wr && wr_ok) begin
        tag_q[g]  <= wr_tag;
        line_q[g] <= wr_line;
        ecc_q[g]  <= wr_ecc;
      end
    end

    assign match[g] = look_en && vld_q[g] && (tag_q[g] == look_tag);
  end

  always_comb begin
    hit      = |match;
    hit_idx  = '0;
    hit_line = '0;
    hit_ecc  = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match[i]) begin
        hit_idx  = IDX_W'(i);
        hit_line = hit_line | line_q[i];
        hit_ecc  = hit_ecc | ecc_q[i];
      end
    end
  end

  assign vld = vld_q;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R4
  AST_ERR_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok && !flush) |=> !vld_q[$past(wr_idx)]); // R8
  AST_ECC_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ok && wr_ecc && !flush) |=> ecc_q[$past(wr_idx)]); // R7
endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl
  import fpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic buf_en,
  input  logic pe_start,
  input  logic bus_valid,
  input  logic bus_nonseq,
  input  logic emu_nz,
  input  logic hit,
  input  logic arr_ack,
  input  logic arr_err,
  output logic look_en,
  output logic flush,
  output logic capture,
  output logic fetching,
  output logic done,
  output logic fill_en,
  output logic fill_ok
);
  fpb_state_e state_q;
  fpb_state_e state_d;
  logic       pend_q;
  logic       pend_d;
  logic       idle_req;
  logic       ns_flush;

  assign idle_req = (state_q == FPB_IDLE) && bus_valid;
  assign ns_flush = idle_req && bus_nonseq && (pend_q || emu_nz);
  assign flush    = ns_flush || !buf_en;
  assign look_en  = idle_req && buf_en && !ns_flush;
  assign capture  = idle_req && !hit;
  assign fetching = (state_q == FPB_FETCH);
  assign done     = fetching && arr_ack;
  assign fill_en  = done && buf_en;
  assign fill_ok  = !arr_err;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FPB_IDLE:  if (capture) state_d = FPB_FETCH;
      FPB_FETCH: if (arr_ack) state_d = FPB_IDLE;
      default:   state_d = FPB_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pe_start || (pend_q && !ns_flush);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FPB_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  AST_PEND_WAITS_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(bus_valid && bus_nonseq && state_q == FPB_IDLE)) |=> pend_q); // R4
  AST_NO_HIT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetching |-> !hit); // R2
endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int LINE_W  = 128,
  parameter int NUM_ENT = 4,
  parameter int EMU_LO  = 24,
  parameter int EMU_HI  = 28
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 buf_en,
  input  logic                                 pe_start,
  input  logic                                 bus_valid,
  input  logic                                 bus_nonseq,
  input  logic [ADDR_W-1:0]                    bus_addr,
  output logic                                 bus_ready,
  output logic [WORD_W-1:0]                    bus_rdata,
  output logic                                 bus_err,
  output logic                                 bus_ecc1,
  output logic                                 arr_req,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0]   arr_addr,
  input  logic                                 arr_ack,
  input  logic [LINE_W-1:0]                    arr_rdata,
  input  logic                                 arr_ecc_corr,
  input  logic                                 arr_err
);
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int PG_OFFS = $clog2(LINE_W / 8);
  localparam int WD_OFFS = $clog2(WORD_W / 8);
  localparam int TAG_W   = ADDR_W - PG_OFFS;
  localparam int SEL_W   = PG_OFFS - WD_OFFS;

  logic               rst_i_n;
  logic               look_en;
  logic               flush;
  logic               capture;
  logic               fetching;
  logic               done;
  logic               fill_en;
  logic               fill_ok;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [LINE_W-1:0]  hit_line;
  logic               hit_ecc;
  logic [NUM_ENT-1:0] vld;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   vict_q;
  logic [TAG_W-1:0]   page_q;
  logic [TAG_W-1:0]   bus_tag;
  logic [SEL_W-1:0]   word_sel;
  logic               emu_nz;
  logic               touch;
  logic [IDX_W-1:0]   touch_idx;
  logic               unused_low_bits;

  assign bus_tag         = bus_addr[ADDR_W-1:PG_OFFS];
  assign word_sel        = bus_addr[PG_OFFS-1:WD_OFFS];
  assign emu_nz          = |bus_addr[EMU_HI:EMU_LO];
  assign unused_low_bits = ^bus_addr[WD_OFFS-1:0];

  fpb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fpb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .buf_en     (buf_en),
    .pe_start   (pe_start),
    .bus_valid  (bus_valid),
    .bus_nonseq (bus_nonseq),
    .emu_nz     (emu_nz),
    .hit        (hit),
    .arr_ack    (arr_ack),
    .arr_err    (arr_err),
    .look_en    (look_en),
    .flush      (flush),
    .capture    (capture),
    .fetching   (fetching),
    .done       (done),
    .fill_en    (fill_en),
    .fill_ok    (fill_ok)
  );

  fpb_store #(
    .NUM_ENT (NUM_ENT),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W),
    .LINE_W  (LINE_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .look_en  (look_en),
    .look_tag (bus_tag),
    .flush    (flush),
    .wr_en    (fill_en),
    .wr_ok    (fill_ok),
    .wr_idx   (vict_q),
    .wr_tag   (page_q),
    .wr_line  (arr_rdata),
    .wr_ecc   (arr_ecc_corr),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .hit_line (hit_line),
    .hit_ecc  (hit_ecc),
    .vld      (vld)
  );

  assign touch     = hit || (fill_en && fill_ok);
  assign touch_idx = hit ? hit_idx : vict_q;

  fpb_lru #(
    .NUM_ENT (NUM_ENT),
    .IDX_W   (IDX_W)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .vld       (vld),
    .touch     (touch),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      page_q <= '0;
      vict_q <= '0;
    end else if (capture) begin
      page_q <= bus_tag;
      vict_q <= victim;
    end
  end

  assign arr_req  = fetching;
  assign arr_addr = page_q;

  always_comb begin
    bus_ready = hit || done;
    bus_err   = done && arr_err;
    bus_ecc1  = (hit && hit_ecc) || (done && !arr_err && arr_ecc_corr);
    bus_rdata = '0;
    if (hit) begin
      bus_rdata = hit_line[word_sel*WORD_W +: WORD_W];
    end else if (done && !arr_err) begin
      bus_rdata = arr_rdata[word_sel*WORD_W +: WORD_W];
    end
  end

  AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (arr_req && !arr_ack) |-> !bus_ready); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (arr_req && !arr_ack) |=> (arr_req && $stable(arr_addr))); // R2
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !buf_en |-> !hit); // R6
  AST_EMU_ADDR_MISSES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_valid && bus_nonseq && !arr_req && emu_nz) |-> !hit); // R5
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_err |-> (bus_ready && bus_rdata == '0 && !bus_ecc1)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> (!bus_ready && !arr_req)); // R9
endmodule

// File: tb/tb_flash_page_buf.sv
module tb_flash_page_buf;
  typedef struct {
    logic [31:0] data;
    bit          err;
    bit          ecc;
    bit          hit;
    string       tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         buf_en;
  logic         pe_start;
  logic         bus_valid;
  logic         bus_nonseq;
  logic [31:0]  bus_addr;
  logic         bus_ready;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic         bus_ecc1;
  logic         arr_req;
  logic [27:0]  arr_addr;
  logic         arr_ack;
  logic [127:0] arr_rdata;
  logic         arr_ecc_corr;
  logic         arr_err;

  int   n_checks;
  int   n_fails;
  int   waits;
  int   fetch_cnt;
  bit   done_all;
  exp_t expq[$];
  logic [27:0] err_page;
  logic [27:0] corr_page;

  flash_page_buf dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_en       (buf_en),
    .pe_start     (pe_start),
    .bus_valid    (bus_valid),
    .bus_nonseq   (bus_nonseq),
    .bus_addr     (bus_addr),
    .bus_ready    (bus_ready),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .bus_ecc1     (bus_ecc1),
    .arr_req      (arr_req),
    .arr_addr     (arr_addr),
    .arr_ack      (arr_ack),
    .arr_rdata    (arr_rdata),
    .arr_ecc_corr (arr_ecc_corr),
    .arr_err      (arr_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
  endfunction

  function automatic logic [31:0] pg(input int n);
    return 32'h0000_1000 + 32'(n) * 32'h10;
  endfunction

  // Array model: acknowledges three cycles after a request appears
  initial begin : arr_model
    int cnt;
    cnt          = 0;
    arr_ack      = 1'b0;
    arr_rdata    = '0;
    arr_err      = 1'b0;
    arr_ecc_corr = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (arr_ack) begin
        arr_ack = 1'b0;
        cnt     = 0;
      end else if (arr_req) begin
        cnt++;
        if (cnt == 3) begin
          for (int k = 0; k < 4; k++) begin
            arr_rdata[k*32 +: 32] = word_of({arr_addr, 2'(k), 2'b00});
          end
          arr_err      = (arr_addr == err_page);
          arr_ecc_corr = (arr_addr == corr_page);
          arr_ack      = 1'b1;
          fetch_cnt++;
        end
      end
    end
  end

  // Monitor: pops one expected item per response
  initial begin : monitor
    exp_t e;
    waits = 0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_valid) begin
        if (!bus_ready) begin
          waits++;
        end else begin
          if (expq.size() == 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL unexpected response: actual data %h expected none", bus_rdata);
          end else begin
            e = expq.pop_front();
            n_checks++;
            if (bus_rdata !== e.data || bus_err !== e.err || bus_ecc1 !== e.ecc ||
                ((waits == 0) != e.hit)) begin
              n_fails++;
              $display("FAIL %s addr %h: actual data %h err %0b ecc %0b waits %0d, expected data %h err %0b ecc %0b hit %0b",
                       e.tag, bus_addr, bus_rdata, bus_err, bus_ecc1, waits,
                       e.data, e.err, e.ecc, e.hit);
            end
          end
          waits = 0;
        end
      end
    end
  end

  task automatic acc(input logic [31:0] a, input bit ns, input bit exp_hit, input string tag);
    exp_t e;
    bit   is_err;
    is_err = (a[31:4] == err_page) && !exp_hit;
    e.tag  = tag;
    e.hit  = exp_hit;
    e.err  = is_err;
    e.ecc  = !is_err && (a[31:4] == corr_page);
    e.data = is_err ? 32'h0 : word_of(a);
    expq.push_back(e);
    bus_addr   = a;
    bus_nonseq = ns;
    bus_valid  = 1'b1;
    do @(negedge clk); while (!bus_ready);
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_all) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : driver
    n_checks   = 0;
    n_fails    = 0;
    fetch_cnt  = 0;
    done_all   = 1'b0;
    err_page   = '1;
    corr_page  = '1;
    rst_n      = 1'b0;
    buf_en     = 1'b1;
    pe_start   = 1'b0;
    bus_valid  = 1'b0;
    bus_nonseq = 1'b1;
    bus_addr   = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check_bit(bus_ready, 1'b0, "R9 ready low after reset");
    check_bit(arr_req, 1'b0, "R9 no fetch after reset");
    @(posedge clk);
    #1;

    // R9 / R2 / R1: first access misses, following words hit
    acc(pg(0),       1'b1, 1'b0, "R9 empty after reset");
    acc(pg(0) + 4,   1'b0, 1'b1, "R1 seq word1 hit");
    acc(pg(0) + 12,  1'b1, 1'b1, "R1 nonseq word3 hit");
    // R3: fill the other lines, then evict least recently used
    acc(pg(1),       1'b1, 1'b0, "R2 miss fill page1");
    acc(pg(2) + 8,   1'b1, 1'b0, "R2 miss fill page2");
    acc(pg(3),       1'b1, 1'b0, "R2 miss fill page3");
    acc(pg(0) + 8,   1'b1, 1'b1, "R3 page0 still held");
    acc(pg(4),       1'b1, 1'b0, "R3 page4 miss");
    acc(pg(0),       1'b1, 1'b1, "R3 page0 kept");
    acc(pg(2),       1'b1, 1'b1, "R3 page2 kept");
    acc(pg(3),       1'b1, 1'b1, "R3 page3 kept");
    acc(pg(4) + 4,   1'b1, 1'b1, "R3 page4 held");
    acc(pg(1),       1'b1, 1'b0, "R3 page1 was victim");
    acc(pg(0),       1'b1, 1'b0, "R3 page0 was victim");
    acc(pg(3) + 12,  1'b1, 1'b1, "R3 page3 hit");
    acc(pg(4),       1'b1, 1'b1, "R3 page4 hit");
    acc(pg(1) + 8,   1'b1, 1'b1, "R3 page1 hit");

    // R4: deferred flush from program/erase start
    @(posedge clk); #1 pe_start = 1'b1;
    @(posedge clk); #1 pe_start = 1'b0;
    acc(pg(3) + 4,   1'b0, 1'b1, "R4 seq beat still hits");
    acc(pg(3) + 8,   1'b0, 1'b1, "R4 second seq beat hits");
    acc(pg(4),       1'b1, 1'b0, "R4 nonseq applies flush");
    acc(pg(4) + 8,   1'b0, 1'b1, "R4 refilled page hits");
    acc(pg(3),       1'b1, 1'b0, "R4 page3 flushed");

    // R5: high address bits flush at once
    acc(32'h0100_1040, 1'b1, 1'b0, "R5 emu access misses");
    acc(32'h0100_1044, 1'b0, 1'b1, "R5 seq beat hits");
    acc(pg(3),       1'b1, 1'b0, "R5 page3 flushed");
    acc(pg(3) + 4,   1'b0, 1'b1, "R5 page3 refilled");
    acc(32'h0100_1040, 1'b1, 1'b0, "R5 emu access flushes again");
    acc(pg(3),       1'b1, 1'b0, "R5 page3 flushed again");

    // R6: disable empties and blocks fills
    @(posedge clk); #1 buf_en = 1'b0;
    acc(pg(3),       1'b1, 1'b0, "R6 disabled miss");
    acc(pg(3),       1'b1, 1'b0, "R6 disabled no fill");
    acc(pg(3) + 4,   1'b0, 1'b0, "R6 disabled seq miss");
    @(posedge clk); #1 buf_en = 1'b1;
    acc(pg(3),       1'b1, 1'b0, "R6 re-enabled empty");
    acc(pg(3) + 4,   1'b0, 1'b1, "R6 re-enabled fills");

    // R7: corrected ECC replay
    corr_page = pg(5) >> 4;
    acc(pg(5),       1'b1, 1'b0, "R7 corrected fill");
    acc(pg(5) + 4,   1'b0, 1'b1, "R7 replay on seq hit");
    acc(pg(5) + 12,  1'b1, 1'b1, "R7 replay on nonseq hit");
    acc(pg(3) + 8,   1'b1, 1'b1, "R7 clean line no flag");

    // R8: uncorrectable fetch leaves line empty
    err_page = pg(6) >> 4;
    acc(pg(6),       1'b1, 1'b0, "R8 error response");
    acc(pg(6) + 4,   1'b1, 1'b0, "R8 line left empty");
    err_page = '1;
    acc(pg(6) + 8,   1'b1, 1'b0, "R8 clean refetch");
    acc(pg(6),       1'b1, 1'b1, "R8 refetched line hits");
    acc(pg(5),       1'b1, 1'b1, "R7 flag kept across fills");

    repeat (3) @(posedge clk);
    n_checks++;
    if (expq.size() != 0) begin
      n_fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expq.size());
    end
    done_all = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule